// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Grid

This block is a square grid of N×N multiply-accumulate cells for 8-bit integer matrix products. Each cell keeps a weight in place. A stream of activation vectors (one N-element row per accepted transfer) enters at the left edge with a diagonal skew: array row k sees its element k cycles after row 0. Partial sums run down each column and leave at the bottom as 32-bit sums. A delay line at the bottom realigns the columns, so each input row yields one N-element result vector with a single valid flag.

Weights arrive from the top through a load stream into a second, shadow copy of the tile. This can happen while the active tile is still computing. An activation row marked as the first of a new block carries a swap token along the same skewed path as its data. Each cell switches to its shadow weight at the moment that row's data reaches it. Rows still in flight finish with the old tile, and the new block can follow the old one with no idle cycle. Each operand has its own signedness flag, which selects sign or zero extension before the multiply.

Top module: `wsa_array`

## Requirements
- R1: For an accepted row with element k at `act_row[8k+:8]`, output element j at `out_sum[32j+:32]` equals the sum over k of ext(a_k)·ext(W[k][j]), modulo 2^32. ext is sign extension when the operand's flag (`act_signed` for the row, `wld_signed` for the weight row) is 1, and zero extension when it is 0.
- R2: Each accepted weight row enters at the top of the shadow tile and pushes the earlier rows down one place. Element j of a weight row (`wld_row[8j+:8]`) belongs to column j. After N loads, the first row loaded sits in array row N-1 and the last in array row 0. No load is accepted once N rows are held.
- R3: An accepted row with `act_first`=1 and every row after it use the shadow tile. Rows accepted before it use the previously active tile, even while both are inside the grid.
- R4: `act_ready` is low exactly when `act_first`=1 and fewer than N weight rows have been loaded since the last swap. Rows with `act_first`=0 are never held back.
- R5: `wld_ready` is low while N rows are held and unswapped. It goes low on the cycle after a swap row is accepted and returns high 2N-2 cycles after that acceptance edge.
- R6: A row accepted at clock edge E appears at edge E+2N-2 (edge E+6 for N=4) with `out_valid` high. All N sums come out together, in acceptance order.
- R7: A block with a new tile can begin on the cycle after the last row of the previous block. The result vectors then come out on consecutive cycles across the tile change.
- R8: A cycle with no accepted row produces no result vector and changes no cell's weight, activation or sum state.
- R9: After reset, `out_valid` is 0, the active weights are zero, the shadow tile counts as empty (`act_ready` is low for a first row), and `wld_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wld_valid | input | 1 | Weight row offered |
| wld_ready | output | 1 | Weight row can be taken |
| wld_row | input | N*8 | Weight row, column j in bits [8j+:8] |
| wld_signed | input | 1 | Weight row is signed |
| act_valid | input | 1 | Activation row offered |
| act_ready | output | 1 | Activation row can be taken |
| act_first | input | 1 | Row starts a block on the shadow tile |
| act_signed | input | 1 | Activation row is signed |
| act_row | input | N*8 | Activations, element k in bits [8k+:8] |
| out_valid | output | 1 | Result vector present |
| out_sum | output | N*32 | Result vector, column j in bits [32j+:32] |

## Verification
On every cycle, the assertions check the diagonal wavefront: each row's valid and swap token reach the east edge one cycle after the row above. They also check that bubbles leave cell state untouched, that a swap only happens over a complete tile with the load window closed after it, and that every accepted row comes out exactly 2N-2 cycles later. The arithmetic itself is shown only by the bench scenarios. These compare every result vector with an integer product computed independently, across all four signedness combinations, extreme byte values, one-hot rows that expose weight placement, rows separated by bubbles, and a back-to-back tile change with rows of both tiles in flight at once.

// File: rtl/wsa_pkg.sv
`timescale 1ns/1ps
package wsa_pkg;
  localparam int OPW  = 8;
  localparam int EXW  = OPW + 1;
  localparam int ACCW = 32;
  localparam int PRW  = 2 * EXW;

  // One activation lane travelling east through a row of cells.
  typedef struct packed {
    logic                  vld;
    logic                  swp;
    logic signed [EXW-1:0] a;
  } lane_t;

  // Sign or zero extension of an 8-bit operand to 9 bits.
  function automatic logic signed [EXW-1:0] widen(input logic [OPW-1:0] v, input logic sgn);
    widen = {sgn & v[OPW-1], v};
  endfunction

  // Multiply two widened operands and add into a wrapping partial sum.
  function automatic logic [ACCW-1:0] mac_step(input logic [ACCW-1:0] acc,
                                               input logic signed [EXW-1:0] a,
                                               input logic signed [EXW-1:0] w);
    logic signed [PRW-1:0] p;
    p = a * w;
    mac_step = acc + {{(ACCW-PRW){p[PRW-1]}}, p};
  endfunction
endpackage

// File: rtl/wsa_skew.sv
`timescale 1ns/1ps
module wsa_skew import wsa_pkg::*; #(
  parameter int N = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  lane_t row_in  [N],
  output lane_t row_out [N]
);
  // Row k is delayed by k registers so a row forms a diagonal wavefront.
  for (genvar k = 0; k < N; k++) begin : g_row
    if (k == 0) begin : g_direct
      assign row_out[k] = row_in[k];
    end else begin : g_delay
      lane_t stg [k];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < k; i++) stg[i] <= '0;
        end else begin
          stg[0] <= row_in[k];
          for (int i = 1; i < k; i++) stg[i] <= stg[i-1];
        end
      end
      assign row_out[k] = stg[k-1];
    end
  end
endmodule

// File: rtl/wsa_wbank.sv
`timescale 1ns/1ps
module wsa_wbank import wsa_pkg::*; #(
  parameter int N = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [N*OPW-1:0]      row,
  input  logic                  sgn,
  input  logic                  swap,
  output logic signed [EXW-1:0] shadow [N][N],
  output logic                  full,
  output logic                  busy
);
  localparam int FW  = $clog2(N + 1);
  localparam int WIN = 2 * N - 2;
  localparam int CW  = $clog2(2 * N);

  logic [FW-1:0] fill_q;
  logic [CW-1:0] win_q;

  assign full = (fill_q == FW'(N));
  assign busy = (win_q != '0);

  // Loaded-row count: cleared when a swap consumes the tile.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fill_q <= '0;
    else if (swap) fill_q <= '0;
    else if (load) fill_q <= fill_q + 1'b1;
  end

  // Window during which the swap wavefront still reads the shadow tile.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    win_q <= '0;
    else if (swap) win_q <= CW'(WIN);
    else if (busy) win_q <= win_q - 1'b1;
  end

  // Shadow tile shifts down one row per accepted load, new row at the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++)
        for (int j = 0; j < N; j++) shadow[k][j] <= '0;
    end else if (load) begin
      for (int j = 0; j < N; j++) shadow[0][j] <= widen(row[j*OPW +: OPW], sgn);
      for (int k = 1; k < N; k++)
        for (int j = 0; j < N; j++) shadow[k][j] <= shadow[k-1][j];
    end
  end
endmodule

// File: rtl/wsa_cell.sv
`timescale 1ns/1ps
module wsa_cell import wsa_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  lane_t                 lane_i,
  output lane_t                 lane_o,
  input  logic signed [EXW-1:0] shadow_w,
  input  logic [ACCW-1:0]       psum_i,
  output logic [ACCW-1:0]       psum_o
);
  logic signed [EXW-1:0] active_w;
  logic signed [EXW-1:0] w_eff;

  // The swap token takes effect for the very row that carries it.
  assign w_eff = lane_i.swp ? shadow_w : active_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_o   <= '0;
      active_w <= '0;
      psum_o   <= '0;
    end else begin
      lane_o.vld <= lane_i.vld;
      if (lane_i.vld) begin
        lane_o.swp <= lane_i.swp;
        lane_o.a   <= lane_i.a;
        psum_o     <= mac_step(psum_i, lane_i.a, w_eff);
        if (lane_i.swp) active_w <= shadow_w;
      end
    end
  end
endmodule

// File: rtl/wsa_deskew.sv
`timescale 1ns/1ps
module wsa_deskew import wsa_pkg::*; #(
  parameter int N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ACCW-1:0] col_in  [N],
  output logic [ACCW-1:0] col_out [N]
);
  // Column j leaves the grid j cycles after column 0; delay it by N-1-j.
  for (genvar j = 0; j < N; j++) begin : g_col
    localparam int D = N - 1 - j;
    if (D == 0) begin : g_direct
      assign col_out[j] = col_in[j];
    end else begin : g_delay
      logic [ACCW-1:0] dl [D];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < D; i++) dl[i] <= '0;
        end else begin
          dl[0] <= col_in[j];
          for (int i = 1; i < D; i++) dl[i] <= dl[i-1];
        end
      end
      assign col_out[j] = dl[D-1];
    end
  end
endmodule

// File: rtl/wsa_array.sv
`timescale 1ns/1ps
module wsa_array import wsa_pkg::*; #(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wld_valid,
  output logic              wld_ready,
  input  logic [N*OPW-1:0]  wld_row,
  input  logic              wld_signed,
  input  logic              act_valid,
  output logic              act_ready,
  input  logic              act_first,
  input  logic              act_signed,
  input  logic [N*OPW-1:0]  act_row,
  output logic              out_valid,
  output logic [N*ACCW-1:0] out_sum
);
  // Named events for the checker.
  logic act_fire, swap_fire, wld_fire;
  logic tile_full, win_busy;

  logic signed [EXW-1:0] shadow [N][N];
  lane_t                 entry  [N];
  lane_t                 skewed [N];
  lane_t                 hl     [N][N+1];
  lane_t                 east   [N];
  logic [ACCW-1:0]       vs     [N+1][N];
  logic [ACCW-1:0]       aligned [N];

  assign act_ready = !act_first || tile_full;
  assign act_fire  = act_valid && act_ready;
  assign swap_fire = act_fire && act_first;
  assign wld_ready = !tile_full && !win_busy;
  assign wld_fire  = wld_valid && wld_ready;

  wsa_wbank #(.N(N)) u_wbank (
    .clk(clk), .rst_n(rst_n), .load(wld_fire), .row(wld_row), .sgn(wld_signed),
    .swap(swap_fire), .shadow(shadow), .full(tile_full), .busy(win_busy)
  );

  for (genvar k = 0; k < N; k++) begin : g_entry
    assign entry[k] = '{vld: act_fire, swp: act_first,
                        a: widen(act_row[k*OPW +: OPW], act_signed)};
  end

  wsa_skew #(.N(N)) u_skew (
    .clk(clk), .rst_n(rst_n), .row_in(entry), .row_out(skewed)
  );

  for (genvar j = 0; j < N; j++) begin : g_top
    assign vs[0][j] = '0;
  end

  for (genvar k = 0; k < N; k++) begin : g_r
    assign hl[k][0] = skewed[k];
    assign east[k]  = hl[k][N];
    for (genvar j = 0; j < N; j++) begin : g_c
      wsa_cell u_cell (
        .clk(clk), .rst_n(rst_n),
        .lane_i(hl[k][j]), .lane_o(hl[k][j+1]),
        .shadow_w(shadow[k][j]),
        .psum_i(vs[k][j]), .psum_o(vs[k+1][j])
      );
    end
  end

  wsa_deskew #(.N(N)) u_deskew (
    .clk(clk), .rst_n(rst_n), .col_in(vs[N]), .col_out(aligned)
  );

  assign out_valid = east[N-1].vld;
  for (genvar j = 0; j < N; j++) begin : g_out
    assign out_sum[j*ACCW +: ACCW] = aligned[j];
  end
endmodule

// File: rtl/wsa_array_chk.sv
`timescale 1ns/1ps
module wsa_array_chk import wsa_pkg::*; #(
  parameter int N = 4
) (
  input logic  clk,
  input logic  rst_n,
  input logic  act_valid,
  input logic  act_ready,
  input logic  act_first,
  input logic  wld_valid,
  input logic  wld_ready,
  input logic  out_valid,
  input lane_t east_lane [N]
);
  localparam int LAT = 2 * N - 2;
  localparam int CW  = $clog2(N + 1);

  logic          fire, swap, ld;
  logic [CW-1:0] ld_cnt;
  logic [LAT:0]  fire_pipe;

  assign fire = act_valid && act_ready;
  assign swap = fire && act_first;
  assign ld   = wld_valid && wld_ready;

  // Independent record of loads since the last swap and of accepted rows.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_cnt    <= '0;
      fire_pipe <= '0;
    end else begin
      if (swap)    ld_cnt <= '0;
      else if (ld) ld_cnt <= ld_cnt + 1'b1;
      fire_pipe <= {fire_pipe[LAT-1:0], fire};
    end
  end

  p_tile_complete_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> ld_cnt == CW'(N));
  p_plain_rows_flow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_first) |-> act_ready);
  p_no_overfill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> ld_cnt < CW'(N));
  p_gap_after_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> !wld_ready);
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == fire_pipe[LAT]);

  for (genvar k = 0; k < N; k++) begin : g_row
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !east_lane[k].vld |-> ($stable(east_lane[k].a) && $stable(east_lane[k].swp)));
    if (k < N - 1) begin : g_wave
      p_wave_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
        east_lane[k+1].vld == $past(east_lane[k].vld));
      p_wave_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        east_lane[k+1].vld |-> east_lane[k+1].swp == $past(east_lane[k].swp));
    end
  end
endmodule

bind wsa_array wsa_array_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_ready(act_ready),
  .act_first(act_first), .wld_valid(wld_valid), .wld_ready(wld_ready),
  .out_valid(out_valid), .east_lane(east)
);

// File: tb/tb_wsa_array.sv
`timescale 1ns/1ps
module tb_wsa_array;
  localparam int N   = 4;
  localparam int LAT = 2 * N - 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wld_valid = 1'b0, wld_signed = 1'b0;
  logic           act_valid = 1'b0, act_first = 1'b0, act_signed = 1'b0;
  logic [N*8-1:0] wld_row = '0, act_row = '0;
  logic           wld_ready, act_ready, out_valid;
  logic [N*32-1:0] out_sum;

  always #2.5 clk = ~clk;

  wsa_array #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .wld_valid(wld_valid), .wld_ready(wld_ready),
    .wld_row(wld_row), .wld_signed(wld_signed), .act_valid(act_valid),
    .act_ready(act_ready), .act_first(act_first), .act_signed(act_signed),
    .act_row(act_row), .out_valid(out_valid), .out_sum(out_sum)
  );

  int checks = 0, errors = 0, cyc = 0;
  int sh [N][N];
  int act_t [N][N];
  int tile_buf [N][N];
  int exp_s [2048][N];
  int exp_c [2048];
  int wr_i = 0, rd_i = 0, run = 0, max_run = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int val(input int raw, input bit s);
    return (s && raw >= 128) ? raw - 256 : raw;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [N*8-1:0] pack_row(input int k);
    logic [N*8-1:0] b;
    for (int j = 0; j < N; j++) b[j*8 +: 8] = tile_buf[k][j][7:0];
    return b;
  endfunction

  function automatic logic [N*8-1:0] row_bits(input int r, input int seed);
    logic [N*8-1:0] b;
    for (int k = 0; k < N; k++) begin
      int v;
      v = (r * 53 + k * 91 + seed * 17 + 7) & 255;
      if (r == 0) v = 255;
      if (r == 1) v = 128;
      if (r == 2) v = 127;
      if (r == 3) v = k & 1;
      b[k*8 +: 8] = v[7:0];
    end
    return b;
  endfunction

  task automatic fill_tile(input int seed);
    for (int k = 0; k < N; k++)
      for (int j = 0; j < N; j++)
        tile_buf[k][j] = (seed * 29 + k * 67 + j * 13 + k * j * 5) & 255;
    tile_buf[0][0] = 128;
    tile_buf[1][1] = 255;
    tile_buf[2][2] = 127;
  endtask

  // R2 model: new row enters the top, older rows move down.
  task automatic load_row(input logic [N*8-1:0] bits, input bit s);
    wld_valid = 1'b1; wld_row = bits; wld_signed = s; #1;
    while (!wld_ready) begin @(negedge clk); #1; end
    for (int k = N - 1; k > 0; k--)
      for (int j = 0; j < N; j++) sh[k][j] = sh[k-1][j];
    for (int j = 0; j < N; j++) sh[0][j] = val(int'(bits[j*8 +: 8]), s);
    @(negedge clk);
    wld_valid = 1'b0;
  endtask

  // First row loaded lands in array row N-1.
  task automatic load_tile(input bit s);
    for (int l = 0; l < N; l++) load_row(pack_row(N - 1 - l), s);
  endtask

  task automatic send_row(input logic [N*8-1:0] bits, input bit s, input bit first);
    act_valid = 1'b1; act_row = bits; act_signed = s; act_first = first; #1;
    while (!act_ready) begin @(negedge clk); #1; end
    if (first) act_t = sh;
    for (int j = 0; j < N; j++) begin
      int sum;
      sum = 0;
      for (int k = 0; k < N; k++) sum += val(int'(bits[k*8 +: 8]), s) * act_t[k][j];
      exp_s[wr_i][j] = sum;
    end
    exp_c[wr_i] = cyc + 1 + LAT;
    wr_i++;
    @(negedge clk);
    act_valid = 1'b0; act_first = 1'b0;
  endtask

  // Output monitor: R1 values, R6 timing and order.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        run++;
        if (run > max_run) max_run = run;
        if (rd_i >= wr_i) chk(1'b0, "R6", "unexpected out_valid", 1, 0);
        else begin
          chk(cyc == exp_c[rd_i], "R6", "output cycle", cyc, exp_c[rd_i]);
          for (int j = 0; j < N; j++)
            chk($signed(out_sum[j*32 +: 32]) == exp_s[rd_i][j], "R1", "column sum",
                $signed(out_sum[j*32 +: 32]), exp_s[rd_i][j]);
          rd_i++;
        end
      end else run = 0;
    end
  end

  task automatic finish_up();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_up();
    end
  end

  initial begin
    for (int k = 0; k < N; k++)
      for (int j = 0; j < N; j++) begin sh[k][j] = 0; act_t[k][j] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(wld_ready == 1'b1, "R9", "wld_ready after reset", wld_ready, 1);
    act_first = 1'b1; #1;
    chk(act_ready == 1'b0, "R9", "first row with empty shadow", act_ready, 0);
    act_first = 1'b0; #1;
    chk(act_ready == 1'b1, "R4", "plain row ready", act_ready, 1);
    @(negedge clk);

    // R2/R4/R5: partial tile blocks a first row, full tile blocks loads
    fill_tile(1);
    for (int l = 0; l < N - 1; l++) load_row(pack_row(N - 1 - l), 1'b0);
    act_first = 1'b1; #1;
    chk(act_ready == 1'b0, "R4", "first row with N-1 rows loaded", act_ready, 0);
    act_first = 1'b0;
    @(negedge clk);
    load_row(pack_row(0), 1'b0);
    #1;
    chk(wld_ready == 1'b0, "R5", "wld_ready with full shadow", wld_ready, 0);
    act_first = 1'b1; #1;
    chk(act_ready == 1'b1, "R4", "first row with full tile", act_ready, 1);
    act_first = 1'b0;
    @(negedge clk);

    // R5: load window after a swap
    send_row(row_bits(5, 1), 1'b0, 1'b1);
    begin
      int n;
      n = 0; #1;
      while (!wld_ready && n < 100) begin n++; @(negedge clk); #1; end
      chk(n == LAT, "R5", "cycles with wld_ready low after swap", n, LAT);
    end
    @(negedge clk);

    // R2: one-hot rows expose each weight row in place
    for (int k = 0; k < N; k++) begin
      logic [N*8-1:0] oh;
      oh = '0; oh[k*8 +: 8] = 8'd1;
      send_row(oh, 1'b0, 1'b0);
    end

    // R1: sweep of weight/activation signedness with extreme bytes
    for (int combo = 0; combo < 4; combo++) begin
      fill_tile(combo + 2);
      load_tile(combo[0]);
      for (int r = 0; r < 20; r++)
        send_row(row_bits(r, combo), combo[1] ^ (r == 7), r == 0);
    end

    // R8: bubbles between rows
    fill_tile(9);
    load_tile(1'b1);
    for (int r = 0; r < 12; r++) begin
      send_row(row_bits(r + 4, 9), 1'b1, r == 0);
      repeat (r % 3) @(negedge clk);
    end
    repeat (LAT + 2) @(negedge clk);
    chk(rd_i == wr_i, "R8", "rows delivered across bubbles", rd_i, wr_i);

    // R3/R7: next tile loads behind the active one, blocks back to back
    fill_tile(11);
    load_tile(1'b0);
    fork
      begin
        for (int r = 0; r < 16; r++) send_row(row_bits(r, 11), 1'b0, r == 0);
      end
      begin
        fill_tile(12);
        load_tile(1'b1);
      end
    join
    for (int r = 0; r < 16; r++) send_row(row_bits(r + 3, 12), 1'b1, r == 0);
    repeat (LAT + 4) @(negedge clk);
    chk(max_run >= 32, "R7", "consecutive output cycles across swap", max_run, 32);
    chk(rd_i == wr_i, "R3", "all rows delivered", rd_i, wr_i);
    finish_up();
  end
endmodule